// File: doc/BRIEF.md
# Channel Map Table with Credits

Each core keeps a small table that maps a 4-bit logical output channel to a 20-bit physical network address. The table is read combinationally, so a lookup can sit in the same pipeline stage as the register-file read. Besides the address, a lookup returns the decoded destination fields: the target input channel, the in-tile position, the tile index, an eight-bit core mask and a flag for memory destinations. It also returns whether a send may go ahead now.

Every entry carries a credit counter for end-to-end flow control. Writing an entry loads a new address and refills its credits to the receiver buffer depth. A permitted send uses up one credit. A credit return from the receiver gives one back. A send is permitted only while the entry holds credit, so an empty entry stalls the sender.

The highest logical channel is a discard channel. It has no stored address and always permits sending. A separate select input lets fetch and fill operations go through channel 0 without naming a channel.

Top module: `chan_route_table`

## Requirements
- R1: After reset every entry holds address 0, unicast, with 0 credits. A lookup of any channel other than 15 reports zero credits and send not permitted.
- R2: A write to channel c (c from 0 to 14) stores the 20-bit address and the multicast flag. The new value is visible to lookups from the cycle after the write edge. The write also sets the entry's credits to MAX_CREDITS (default 4), and this overrides a same-cycle send or credit return on that entry.
- R3: A send on an entry with nonzero credits lowers its count by one. A send on an entry with zero credits is ignored, and the count stays at 0.
- R4: Channel 15 is the discard channel. A lookup of it reports lk_null=1, lk_can_send=1, address 0, mask 0, credits 0 and unicast. Writes, sends and credit returns addressed to it change nothing.
- R5: When lk_fetch=1, the lookup uses channel 0 whatever lk_ch holds.
- R6: lk_can_send is 1 exactly when the looked-up channel is 15 or its credit count is nonzero.
- R7: For a unicast entry the address fields are: input channel = bits 3:0, position = bits 11:4, tile = bits 19:12. Positions 0 to 7 are cores, and lk_mask is then the one-hot bit for that position. Positions 8 and up are memory banks, and lk_mask is then 0 with lk_to_mem=1.
- R8: For a multicast entry, lk_mask = address bits 11:4, where mask bit 0 is the core at position 0. The input channel is bits 3:0, and lk_to_mem=0.
- R9: A credit return raises the count by one, up to a ceiling of MAX_CREDITS. A return at the ceiling is ignored.
- R10: A permitted send and a credit return on the same entry in the same cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry |
| wr_ch | input | 4 | Logical channel to load |
| wr_addr | input | 20 | Physical address to store |
| wr_mcast | input | 1 | Stored address is a multicast address |
| send_en | input | 1 | A word is sent this cycle |
| send_ch | input | 4 | Logical channel of the send |
| ret_en | input | 1 | A credit comes back this cycle |
| ret_ch | input | 4 | Logical channel receiving the credit |
| lk_ch | input | 4 | Logical channel to look up |
| lk_fetch | input | 1 | Look up the fetch channel (0) instead of lk_ch |
| lk_addr | output | 20 | Physical address |
| lk_mcast | output | 1 | Entry is multicast |
| lk_dchan | output | 4 | Destination input channel |
| lk_pos | output | 8 | In-tile position (unicast) |
| lk_tile | output | 8 | Tile index (unicast) |
| lk_mask | output | 8 | Target core mask |
| lk_to_mem | output | 1 | Unicast destination is a memory bank |
| lk_null | output | 1 | Lookup hit the discard channel |
| lk_credits | output | 3 | Current credit count |
| lk_can_send | output | 1 | Send permitted now |

## Verification
The bench drains an entry to zero and then sends once more. A counter that wraps would report 7 credits and allow the send. It returns credits at the ceiling, where a missing saturation would go past MAX_CREDITS. It fires a send and a return together on one entry, a case that a design giving priority to one of them would move by one. It overlaps a write with a send, and a design where the send wins would leave the entry one short after the reload. It also checks that writes and sends aimed at the discard channel cannot give it an address or a credit state. Fetch lookups must ignore lk_ch, and unicast core and memory positions must yield a one-hot mask or no mask.

// File: rtl/chan_route_table.sv
module chan_route_table #(
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 20,
  parameter int MASK_W      = 8,
  parameter int DCH_W       = 4,
  parameter int MAX_CREDITS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(NUM_CH)-1:0]         wr_ch,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic                              wr_mcast,
  input  logic                              send_en,
  input  logic [$clog2(NUM_CH)-1:0]         send_ch,
  input  logic                              ret_en,
  input  logic [$clog2(NUM_CH)-1:0]         ret_ch,
  input  logic [$clog2(NUM_CH)-1:0]         lk_ch,
  input  logic                              lk_fetch,
  output logic [ADDR_W-1:0]                 lk_addr,
  output logic                              lk_mcast,
  output logic [DCH_W-1:0]                  lk_dchan,
  output logic [MASK_W-1:0]                 lk_pos,
  output logic [ADDR_W-MASK_W-DCH_W-1:0]    lk_tile,
  output logic [MASK_W-1:0]                 lk_mask,
  output logic                              lk_to_mem,
  output logic                              lk_null,
  output logic [$clog2(MAX_CREDITS+1)-1:0]  lk_credits,
  output logic                              lk_can_send
);
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CRED_W   = $clog2(MAX_CREDITS + 1);
  localparam int TILE_W   = ADDR_W - MASK_W - DCH_W;
  localparam int NULL_CH  = NUM_CH - 1;
  localparam int FETCH_CH = 0;

  logic [ADDR_W-1:0] addr_q [NUM_CH];
  logic              mc_q   [NUM_CH];
  logic [CRED_W-1:0] cred_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    if (g == NULL_CH) begin : g_null
      assign addr_q[g] = '0;
      assign mc_q[g]   = 1'b0;
      assign cred_q[g] = '0;
    end else begin : g_live
      logic wr_hit, snd_hit, ret_hit, full;
      assign full    = cred_q[g] == CRED_W'(MAX_CREDITS);
      assign wr_hit  = wr_en && wr_ch == CH_W'(g);
      assign snd_hit = send_en && send_ch == CH_W'(g) && cred_q[g] != '0;
      assign ret_hit = ret_en && ret_ch == CH_W'(g);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          addr_q[g] <= '0;
          mc_q[g]   <= 1'b0;
          cred_q[g] <= '0;
        end else if (wr_hit) begin
          addr_q[g] <= wr_addr;
          mc_q[g]   <= wr_mcast;
          cred_q[g] <= CRED_W'(MAX_CREDITS);
        end else if (snd_hit && !ret_hit) begin
          cred_q[g] <= cred_q[g] - 1'b1;
        end else if (ret_hit && !snd_hit && !full) begin
          cred_q[g] <= cred_q[g] + 1'b1;
        end
      end
    end
  end

  logic [CH_W-1:0] sel_ch;
  logic            core_pos;

  assign sel_ch      = lk_fetch ? CH_W'(FETCH_CH) : lk_ch;
  assign lk_null     = sel_ch == CH_W'(NULL_CH);
  assign lk_addr     = addr_q[sel_ch];
  assign lk_mcast    = mc_q[sel_ch];
  assign lk_credits  = cred_q[sel_ch];
  assign lk_can_send = lk_null || lk_credits != '0;

  assign lk_dchan = lk_addr[DCH_W-1:0];
  assign lk_pos   = lk_addr[DCH_W +: MASK_W];
  assign lk_tile  = lk_addr[ADDR_W-1 -: TILE_W];
  assign core_pos = lk_pos < MASK_W'(MASK_W);

  assign lk_to_mem = !lk_null && !lk_mcast && !core_pos;
  assign lk_mask   = lk_mcast ? lk_pos :
                     (core_pos && !lk_null) ? (MASK_W'(1) << lk_pos) : '0;
endmodule

// File: rtl/chan_route_table_chk.sv
module chan_route_table_chk #(
  parameter int NUM_CH      = 16,
  parameter int MASK_W      = 8,
  parameter int MAX_CREDITS = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [$clog2(NUM_CH)-1:0]        wr_ch,
  input logic                             send_en,
  input logic [$clog2(NUM_CH)-1:0]        send_ch,
  input logic                             ret_en,
  input logic [$clog2(NUM_CH)-1:0]        ret_ch,
  input logic [$clog2(NUM_CH)-1:0]        lk_ch,
  input logic                             lk_fetch,
  input logic                             lk_mcast,
  input logic [MASK_W-1:0]                lk_mask,
  input logic                             lk_to_mem,
  input logic                             lk_null,
  input logic [$clog2(MAX_CREDITS+1)-1:0] lk_credits,
  input logic                             lk_can_send
);
  localparam int CRED_W = $clog2(MAX_CREDITS + 1);

  a_r4_null_permits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_null |-> lk_can_send);

  a_r6_empty_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_null && lk_credits == '0) |-> !lk_can_send);

  a_r9_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    lk_credits <= CRED_W'(MAX_CREDITS));

  a_r7_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_mcast |-> $onehot0(lk_mask));

  a_r8_mcast_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    lk_mcast |-> !lk_to_mem);

  a_r10_coincide_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && ret_en && send_ch == ret_ch && lk_ch == send_ch && !lk_fetch &&
     !lk_null && lk_can_send && !(wr_en && wr_ch == send_ch))
    |=> (!($stable(lk_ch) && $stable(lk_fetch)) || $stable(lk_credits)));

  a_r3_send_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && !ret_en && lk_ch == send_ch && !lk_fetch && !lk_null &&
     lk_credits != '0 && !wr_en)
    |=> (!($stable(lk_ch) && $stable(lk_fetch)) ||
         lk_credits == $past(lk_credits) - 1'b1));
endmodule

bind chan_route_table chan_route_table_chk #(
  .NUM_CH(NUM_CH), .MASK_W(MASK_W), .MAX_CREDITS(MAX_CREDITS)
) u_chk (.*);

// File: tb/chan_route_table_tb_top.sv
module chan_route_table_tb_top;
  localparam int MAXC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_mcast = 1'b0;
  logic [3:0]  wr_ch = '0;
  logic [19:0] wr_addr = '0;
  logic        send_en = 1'b0, ret_en = 1'b0, lk_fetch = 1'b0;
  logic [3:0]  send_ch = '0, ret_ch = '0, lk_ch = '0;
  logic [19:0] lk_addr;
  logic        lk_mcast, lk_to_mem, lk_null, lk_can_send;
  logic [3:0]  lk_dchan;
  logic [7:0]  lk_pos, lk_tile, lk_mask;
  logic [2:0]  lk_credits;

  int tests = 0, fails = 0;

  chan_route_table dut_i (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; send_en = 1'b0; ret_en = 1'b0;
  endtask

  task automatic look(input logic [3:0] ch, input logic f);
    lk_ch = ch; lk_fetch = f; #1;
  endtask

  task automatic put(input logic [3:0] ch, input logic [19:0] a, input logic m);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_mcast = m; tick();
  endtask

  task automatic t_reset();
    look(4'd3, 1'b0);
    chk("R1 addr", lk_addr, 0);
    chk("R1 credits", lk_credits, 0);
    chk("R1 can_send", lk_can_send, 0);
  endtask

  task automatic t_unicast();
    put(4'd3, {8'h5A, 8'd6, 4'd2}, 1'b0);
    look(4'd3, 1'b0);
    chk("R2 addr", lk_addr, 20'h5A062);
    chk("R2 credits", lk_credits, MAXC);
    chk("R7 tile", lk_tile, 8'h5A);
    chk("R7 pos", lk_pos, 6);
    chk("R7 dchan", lk_dchan, 2);
    chk("R7 core mask", lk_mask, 8'h40);
    chk("R7 to_mem", lk_to_mem, 0);
    put(4'd5, {8'h11, 8'd9, 4'd7}, 1'b0);
    look(4'd5, 1'b0);
    chk("R7 mem to_mem", lk_to_mem, 1);
    chk("R7 mem mask", lk_mask, 0);
  endtask

  task automatic t_mcast();
    put(4'd7, {8'h00, 8'hA5, 4'd4}, 1'b1);
    look(4'd7, 1'b0);
    chk("R8 mcast", lk_mcast, 1);
    chk("R8 mask", lk_mask, 8'hA5);
    chk("R8 dchan", lk_dchan, 4);
    chk("R8 to_mem", lk_to_mem, 0);
  endtask

  task automatic t_fetch();
    put(4'd0, 20'hABCDE, 1'b0);
    look(4'd9, 1'b1);
    chk("R5 fetch addr", lk_addr, 20'hABCDE);
    look(4'd15, 1'b1);
    chk("R5 fetch not null", lk_null, 0);
  endtask

  task automatic t_drain();
    look(4'd3, 1'b0);
    for (int i = 0; i < MAXC; i++) begin
      send_en = 1'b1; send_ch = 4'd3; tick();
    end
    chk("R3 drained", lk_credits, 0);
    chk("R6 stall", lk_can_send, 0);
    send_en = 1'b1; send_ch = 4'd3; tick();
    chk("R3 send at zero ignored", lk_credits, 0);
    ret_en = 1'b1; ret_ch = 4'd3; tick();
    chk("R9 return", lk_credits, 1);
    chk("R6 permit", lk_can_send, 1);
  endtask

  task automatic t_saturate();
    look(4'd7, 1'b0);
    ret_en = 1'b1; ret_ch = 4'd7; tick();
    chk("R9 saturate", lk_credits, MAXC);
  endtask

  task automatic t_coincide();
    look(4'd7, 1'b0);
    send_en = 1'b1; send_ch = 4'd7; tick();
    chk("R3 one taken", lk_credits, MAXC - 1);
    send_en = 1'b1; send_ch = 4'd7; ret_en = 1'b1; ret_ch = 4'd7; tick();
    chk("R10 unchanged", lk_credits, MAXC - 1);
    send_en = 1'b1; send_ch = 4'd7; wr_en = 1'b1; wr_ch = 4'd7;
    wr_addr = 20'h00334; wr_mcast = 1'b0; tick();
    chk("R2 write beats send", lk_credits, MAXC);
    chk("R2 new addr", lk_addr, 20'h00334);
  endtask

  task automatic t_null();
    put(4'd15, 20'hFFFFF, 1'b1);
    send_en = 1'b1; send_ch = 4'd15; tick();
    ret_en = 1'b1; ret_ch = 4'd15; tick();
    look(4'd15, 1'b0);
    chk("R4 null flag", lk_null, 1);
    chk("R4 can_send", lk_can_send, 1);
    chk("R4 addr", lk_addr, 0);
    chk("R4 mask", lk_mask, 0);
    chk("R4 credits", lk_credits, 0);
    chk("R4 mcast", lk_mcast, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unicast();
        t_mcast();
        t_fetch();
        t_drain();
        t_saturate();
        t_coincide();
        t_null();
      end
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule